// File: doc/BRIEF.md
# Indexed CMOS Byte Bank with Checksum Walker

This block holds the 128-byte battery-backed byte store of a PC-style clock chip behind a two-address byte bus. The host first writes an index to the even address, then reads or writes the selected byte through the odd address. Four control bytes sit at indices 10 to 13. The first holds an update-in-progress flag that software cannot write. The second carries a set-mode bit. The third is a status byte that clears itself when read. The fourth is a fixed, read-only status byte.

A second write-only side port lets firmware preload the non-volatile bytes. When it writes into the checksummed window 0x10..0x2D, a sequential walker adds up the thirty bytes of that window, one byte per clock. It then stores the 16-bit total: the high byte goes to 0x2E and the low byte to 0x2F. The timekeeping, alarm and periodic logic lives outside this block. That logic reads control bytes A and B from this block and sends back update strobes and event flags, which set status byte C and raise the level interrupt.

Top module: `cmos_regbank`

## Requirements
- R1: A bus write to the even address (bus_addr=0) loads bits 6:0 of the data as the index, and bit 7 is dropped. A bus read from the even address returns 0xFF.
- R2: A bus write to the odd address stores the byte at the current index, and a bus read from the odd address returns it in the same cycle. This holds for every index except 10..13.
- R3: After reset, index 10 (A) reads 0x26, index 11 (B) reads 0x02, index 12 (C) reads 0x00 and index 13 (D) reads 0x80, and irq is low.
- R4: A bus write to index 10 updates bits 6:0 of A only. Bit 7 of A (update flag) keeps its value.
- R5: An upd_start pulse sets A bit 7 only while B bit 7 (set mode) is 0. An upd_end pulse clears A bit 7. A bus write to B with bit 7 at 1 also clears A bit 7.
- R6: Bus writes to index 12 and index 13 leave those bytes unchanged.
- R7: evt_flags bits {2,1,0} (periodic, alarm, update) set C bits {6,5,4} and C bit 7, and raise irq. irq is a level that stays high until C is read.
- R8: A bus read of index 12 returns C, then clears C to 0x00 and drops irq. If an event flag arrives in the same cycle, only the new event's bits survive the clear.
- R9: A side-port write to an index in 0x10..0x2D raises csum_busy in the next cycle. Thirty cycles later, the 16-bit sum of bytes 0x10..0x2D is stored, high byte at 0x2E and low byte at 0x2F.
- R10: A side-port write into the window while csum_busy is high restarts the walk, so busy then lasts exactly thirty cycles from that write.
- R11: A side-port index of 128 or more (nv_idx bit 7 set) stores nothing and raises nv_err for one cycle. A side write outside the window stores the byte and leaves csum_busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 selects the index address, 1 selects the data address |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data (combinational) |
| nv_wr | input | 1 | Side-port write strobe |
| nv_idx | input | 8 | Side-port byte index |
| nv_wdata | input | 8 | Side-port write data |
| nv_err | output | 1 | One-cycle flag for a rejected side-port index |
| csum_busy | output | 1 | Checksum walk in progress |
| upd_start | input | 1 | Time update begins (sets update flag) |
| upd_end | input | 1 | Time update finished (clears update flag) |
| evt_flags | input | 3 | Event pulses: periodic, alarm, update |
| reg_a_q | output | 8 | Current control byte A |
| reg_b_q | output | 8 | Current control byte B |
| irq | output | 1 | Level interrupt request |

## Verification
The bench uses the default parameters: a 7-bit index with the checksum window at 0x10..0x2D and its result at 0x2E/0x2F. This makes the full 30-cycle walk observable, along with a restart five cycles into a walk. The 8-bit side index leaves bit 7 free, so an out-of-range write that would alias onto byte 5 can be shown to store nothing. Status-byte races are covered by placing a read of C and an alarm event in the same cycle.

// File: rtl/cmos_regbank_pkg.sv
package cmos_regbank_pkg;
  localparam int BYTE_W = 8;
  localparam int SUM_W  = 16;

  // widen a byte and add it into the running checksum
  function automatic logic [SUM_W-1:0] csum_add(input logic [SUM_W-1:0] acc,
                                                input logic [BYTE_W-1:0] b);
    return acc + {{(SUM_W-BYTE_W){1'b0}}, b};
  endfunction

  // host write to control byte A: bits 6:0 from the bus, update flag untouched
  function automatic logic [BYTE_W-1:0] keep_flag(input logic [BYTE_W-1:0] old_v,
                                                  input logic [BYTE_W-1:0] wd);
    return {old_v[BYTE_W-1], wd[BYTE_W-2:0]};
  endfunction

  // fold event pulses {periodic, alarm, update} into status byte C
  function automatic logic [BYTE_W-1:0] fold_events(input logic [BYTE_W-1:0] c_v,
                                                    input logic [2:0] ev);
    return (|ev) ? (c_v | {1'b1, ev, 4'h0}) : c_v;
  endfunction
endpackage

// File: rtl/cmos_csum_walker.sv
module cmos_csum_walker
  import cmos_regbank_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int FIRST = 16,
  parameter int LAST  = 45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              busy,
  output logic              done,
  output logic [SUM_W-1:0]  sum
);
  logic [IDX_W-1:0] ptr;
  logic [SUM_W-1:0] acc;

  assign rd_idx = ptr;
  assign sum    = csum_add(acc, rd_byte);
  assign done   = busy && (ptr == IDX_W'(LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= IDX_W'(FIRST);
      acc  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      ptr  <= IDX_W'(FIRST);
      acc  <= '0;
    end else if (busy) begin
      acc <= sum;
      if (ptr == IDX_W'(LAST)) busy <= 1'b0;
      else                     ptr  <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/cmos_ctrl_regs.sv
module cmos_ctrl_regs
  import cmos_regbank_pkg::*;
#(
  parameter int              IDX_W = 7,
  parameter int              IDX_A = 10,
  parameter int              IDX_B = 11,
  parameter logic [7:0]      A_RST = 8'h26,
  parameter logic [7:0]      B_RST = 8'h02,
  parameter logic [7:0]      D_VAL = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rd_c,
  input  logic              upd_start,
  input  logic              upd_end,
  input  logic [2:0]        evt,
  output logic [BYTE_W-1:0] reg_a,
  output logic [BYTE_W-1:0] reg_b,
  output logic [BYTE_W-1:0] reg_c,
  output logic [BYTE_W-1:0] reg_d,
  output logic              irq
);
  logic wr_a, wr_b, uip_n;
  logic [BYTE_W-1:0] a_n, c_n;

  assign wr_a  = wr_en && (idx == IDX_W'(IDX_A));
  assign wr_b  = wr_en && (idx == IDX_W'(IDX_B));
  assign reg_d = D_VAL;

  always_comb begin
    uip_n = reg_a[BYTE_W-1];
    if (upd_end)                         uip_n = 1'b0;
    if (upd_start && !reg_b[BYTE_W-1])   uip_n = 1'b1;
    if (wr_b && wdata[BYTE_W-1])         uip_n = 1'b0;
    a_n = wr_a ? keep_flag(reg_a, wdata) : reg_a;
    a_n[BYTE_W-1] = uip_n;
    c_n = fold_events(rd_c ? '0 : reg_c, evt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a <= A_RST;
      reg_b <= B_RST;
      reg_c <= '0;
      irq   <= 1'b0;
    end else begin
      reg_a <= a_n;
      if (wr_b) reg_b <= wdata;
      reg_c <= c_n;
      irq   <= (|evt) ? 1'b1 : (rd_c ? 1'b0 : irq);
    end
  end
endmodule

// File: rtl/cmos_regbank.sv
module cmos_regbank
  import cmos_regbank_pkg::*;
#(
  parameter int         IDX_W    = 7,
  parameter int         CK_FIRST = 16,
  parameter int         CK_LAST  = 45,
  parameter int         CK_HI    = 46,
  parameter int         CK_LO    = 47,
  parameter int         IDX_A    = 10,
  parameter logic [7:0] A_RST    = 8'h26,
  parameter logic [7:0] B_RST    = 8'h02,
  parameter logic [7:0] D_VAL    = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              nv_wr,
  input  logic [IDX_W:0]    nv_idx,
  input  logic [7:0]        nv_wdata,
  output logic              nv_err,
  output logic              csum_busy,
  input  logic              upd_start,
  input  logic              upd_end,
  input  logic [2:0]        evt_flags,
  output logic [7:0]        reg_a_q,
  output logic [7:0]        reg_b_q,
  output logic              irq
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int IDX_B = IDX_A + 1;
  localparam int IDX_C = IDX_A + 2;
  localparam int IDX_D = IDX_A + 3;

  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] reg_c, reg_d;

  // named internal events
  logic idx_wr, data_wr, data_rd, rd_c, is_ctrl;
  logic nv_ok, nv_bad, csum_start, csum_done;
  logic [IDX_W-1:0] walk_idx;
  logic [SUM_W-1:0] walk_sum;

  assign idx_wr     = bus_wr && !bus_addr;
  assign data_wr    = bus_wr && bus_addr;
  assign data_rd    = bus_rd && bus_addr;
  assign rd_c       = data_rd && (idx_q == IDX_W'(IDX_C));
  assign is_ctrl    = (idx_q >= IDX_W'(IDX_A)) && (idx_q <= IDX_W'(IDX_D));
  assign nv_bad     = nv_wr && nv_idx[IDX_W];
  assign nv_ok      = nv_wr && !nv_idx[IDX_W];
  assign csum_start = nv_ok && (nv_idx[IDX_W-1:0] >= IDX_W'(CK_FIRST))
                            && (nv_idx[IDX_W-1:0] <= IDX_W'(CK_LAST));

  cmos_ctrl_regs #(
    .IDX_W(IDX_W), .IDX_A(IDX_A), .IDX_B(IDX_B),
    .A_RST(A_RST), .B_RST(B_RST), .D_VAL(D_VAL)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .idx(idx_q), .wdata(bus_wdata),
    .rd_c(rd_c), .upd_start(upd_start), .upd_end(upd_end), .evt(evt_flags),
    .reg_a(reg_a_q), .reg_b(reg_b_q), .reg_c(reg_c), .reg_d(reg_d), .irq(irq)
  );

  cmos_csum_walker #(.IDX_W(IDX_W), .FIRST(CK_FIRST), .LAST(CK_LAST)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(csum_start), .rd_idx(walk_idx),
    .rd_byte(mem[walk_idx]), .busy(csum_busy), .done(csum_done), .sum(walk_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      nv_err <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      nv_err <= nv_bad;
      if (idx_wr) idx_q <= bus_wdata[IDX_W-1:0];
      if (data_wr && !is_ctrl) mem[idx_q] <= bus_wdata;
      if (nv_ok) mem[nv_idx[IDX_W-1:0]] <= nv_wdata;
      if (csum_done) begin
        mem[CK_HI] <= walk_sum[SUM_W-1:BYTE_W];
        mem[CK_LO] <= walk_sum[BYTE_W-1:0];
      end
    end
  end

  always_comb begin
    if (!bus_addr) bus_rdata = 8'hFF;
    else if (idx_q == IDX_W'(IDX_A)) bus_rdata = reg_a_q;
    else if (idx_q == IDX_W'(IDX_B)) bus_rdata = reg_b_q;
    else if (idx_q == IDX_W'(IDX_C)) bus_rdata = reg_c;
    else if (idx_q == IDX_W'(IDX_D)) bus_rdata = reg_d;
    else bus_rdata = mem[idx_q];
  end
endmodule

// File: rtl/cmos_regbank_chk.sv
module cmos_regbank_chk #(
  parameter int IDX_W = 7,
  parameter int IDX_A = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             data_wr,
  input logic [IDX_W-1:0] idx_q,
  input logic [7:0]       bus_wdata,
  input logic             rd_c,
  input logic [2:0]       evt_flags,
  input logic             upd_start,
  input logic             upd_end,
  input logic [7:0]       reg_a_q,
  input logic [7:0]       reg_c,
  input logic             irq,
  input logic             nv_wr,
  input logic             nv_bad_idx,
  input logic             nv_err,
  input logic             csum_start,
  input logic             csum_busy
);
  logic wr_a, wr_b, wr_c, quiet;
  assign wr_a  = data_wr && (idx_q == IDX_W'(IDX_A));
  assign wr_b  = data_wr && (idx_q == IDX_W'(IDX_A + 1));
  assign wr_c  = data_wr && (idx_q == IDX_W'(IDX_A + 2));
  assign quiet = !upd_start && !upd_end;

  assert_uip_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a && quiet |=> reg_a_q[7] == $past(reg_a_q[7]));

  assert_set_clears_uip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b && bus_wdata[7] |=> !reg_a_q[7]);

  assert_c_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c && !rd_c && (evt_flags == 3'b000) |=> $stable(reg_c));

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !rd_c |=> irq);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_c && (evt_flags == 3'b000) |=> !irq && (reg_c == 8'h00));

  assert_walk_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    csum_start |=> csum_busy);

  assert_bad_index_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr && nv_bad_idx |=> nv_err);
endmodule

bind cmos_regbank cmos_regbank_chk #(.IDX_W(IDX_W), .IDX_A(IDX_A)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .idx_q(idx_q), .bus_wdata(bus_wdata),
  .rd_c(rd_c), .evt_flags(evt_flags), .upd_start(upd_start), .upd_end(upd_end),
  .reg_a_q(reg_a_q), .reg_c(reg_c), .irq(irq), .nv_wr(nv_wr),
  .nv_bad_idx(nv_idx[IDX_W]), .nv_err(nv_err), .csum_start(csum_start),
  .csum_busy(csum_busy)
);

// File: tb/tb_cmos_regbank.sv
module tb_cmos_regbank;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic nv_wr = 1'b0, nv_err, csum_busy;
  logic [7:0] nv_idx = '0, nv_wdata = '0;
  logic upd_start = 1'b0, upd_end = 1'b0;
  logic [2:0] evt_flags = '0;
  logic [7:0] reg_a_q, reg_b_q;
  logic irq;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] nvm [128];

  always #5 clk = ~clk;

  cmos_regbank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nv_wr(nv_wr), .nv_idx(nv_idx),
    .nv_wdata(nv_wdata), .nv_err(nv_err), .csum_busy(csum_busy), .upd_start(upd_start),
    .upd_end(upd_end), .evt_flags(evt_flags), .reg_a_q(reg_a_q), .reg_b_q(reg_b_q), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: every bus read pops one expected byte
  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      if (exp_q.size() == 0) check("unexpected read", 32'd1, 32'd0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, {24'h0, bus_rdata}, {24'h0, e});
      end
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    step(); bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    step(); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, input logic [7:0] exp, input string tag);
    step(); exp_q.push_back(exp); tag_q.push_back(tag); bus_addr = a; bus_rd = 1'b1;
    step(); bus_rd = 1'b0;
  endtask

  task automatic read_idx(input logic [6:0] i, input logic [7:0] exp, input string tag);
    bus_write(1'b0, {1'b0, i});
    bus_read(1'b1, exp, tag);
  endtask

  task automatic write_idx(input logic [6:0] i, input logic [7:0] d);
    bus_write(1'b0, {1'b0, i});
    bus_write(1'b1, d);
  endtask

  task automatic nv_write(input logic [7:0] i, input logic [7:0] d);
    step(); nv_wr = 1'b1; nv_idx = i; nv_wdata = d;
    step(); nv_wr = 1'b0;
    if (!i[7]) nvm[i[6:0]] = d;
  endtask

  task automatic pulse_evt(input logic [2:0] f);
    step(); evt_flags = f;
    step(); evt_flags = '0;
  endtask

  function automatic logic [15:0] model_sum();
    logic [15:0] s = '0;
    for (int i = 16; i <= 45; i++) s = s + {8'h0, nvm[i]};
    return s;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n;
    logic [15:0] s;
    for (int i = 0; i < 128; i++) nvm[i] = 8'h00;
    repeat (3) step();
    rst_n = 1'b1;

    // R3 reset state
    check("R3 irq", irq, 0);
    read_idx(7'd10, 8'h26, "R3 A");
    read_idx(7'd11, 8'h02, "R3 B");
    read_idx(7'd12, 8'h00, "R3 C");
    read_idx(7'd13, 8'h80, "R3 D");

    // R1 index latch drops bit 7; even read gives 0xFF
    bus_write(1'b0, 8'h8A);
    bus_read(1'b1, 8'h26, "R1 index bit7 dropped");
    bus_read(1'b0, 8'hFF, "R1 even read");

    // R2 round trips
    write_idx(7'd3, 8'h5A);
    write_idx(7'd100, 8'hC3);
    read_idx(7'd3, 8'h5A, "R2 byte 3");
    read_idx(7'd100, 8'hC3, "R2 byte 100");

    // R4 / R5 update flag handling
    pulse_evt(3'b000);
    step(); upd_start = 1'b1; step(); upd_start = 1'b0;
    check("R5 upd_start sets flag", reg_a_q, 8'hA6);
    write_idx(7'd10, 8'h05);
    read_idx(7'd10, 8'h85, "R4 flag kept on A write");
    step(); upd_end = 1'b1; step(); upd_end = 1'b0;
    check("R5 upd_end clears flag", reg_a_q, 8'h05);
    step(); upd_start = 1'b1; step(); upd_start = 1'b0;
    write_idx(7'd11, 8'h82);
    read_idx(7'd10, 8'h05, "R5 set mode clears flag");
    step(); upd_start = 1'b1; step(); upd_start = 1'b0;
    check("R5 no set during set mode", reg_a_q, 8'h05);
    write_idx(7'd11, 8'h02);
    check("R5 B written", reg_b_q, 8'h02);

    // R6 C and D ignore writes
    write_idx(7'd12, 8'hFF);
    read_idx(7'd12, 8'h00, "R6 C write ignored");
    check("R6 irq untouched", irq, 0);
    write_idx(7'd13, 8'h00);
    read_idx(7'd13, 8'h80, "R6 D write ignored");

    // R7 events set C and irq, level held
    pulse_evt(3'b100);
    check("R7 irq raised", irq, 1);
    repeat (5) step();
    check("R7 irq held", irq, 1);
    pulse_evt(3'b001);
    // R8 read returns then clears
    read_idx(7'd12, 8'hD0, "R8 C value");
    check("R8 irq dropped", irq, 0);
    bus_read(1'b1, 8'h00, "R8 C cleared");

    // R8 event in same cycle as read survives
    pulse_evt(3'b100);
    step(); exp_q.push_back(8'hC0); tag_q.push_back("R8 race read");
    bus_addr = 1'b1; bus_rd = 1'b1; evt_flags = 3'b010;
    step(); bus_rd = 1'b0; evt_flags = '0;
    check("R8 race irq", irq, 1);
    bus_read(1'b1, 8'hA0, "R8 race new event kept");
    check("R8 irq after clear", irq, 0);

    // R9 checksum walk
    nv_write(8'h10, 8'hF0);
    check("R9 busy raised", csum_busy, 1);
    n = 0;
    while (csum_busy && n < 100) begin step(); n++; end
    check("R9 walk length", n, 30);
    s = model_sum();
    read_idx(7'd46, s[15:8], "R9 sum high");
    read_idx(7'd47, s[7:0], "R9 sum low");
    nv_write(8'h2D, 8'hFF);
    nv_write(8'h1F, 8'h80);
    while (csum_busy) step();
    s = model_sum();
    read_idx(7'd46, s[15:8], "R9 sum high two bytes");
    read_idx(7'd47, s[7:0], "R9 sum low two bytes");

    // R10 restart mid-walk
    nv_write(8'h20, 8'h33);
    repeat (5) step();
    nv_write(8'h21, 8'h44);
    n = 0;
    while (csum_busy && n < 100) begin step(); n++; end
    check("R10 restart length", n, 30);
    s = model_sum();
    read_idx(7'd46, s[15:8], "R10 sum high");
    read_idx(7'd47, s[7:0], "R10 sum low");

    // R11 rejected index and outside-window write
    write_idx(7'd5, 8'h11);
    nv_write(8'h85, 8'hEE);
    check("R11 nv_err", nv_err, 1);
    step();
    check("R11 nv_err one cycle", nv_err, 0);
    read_idx(7'd5, 8'h11, "R11 no alias write");
    nv_write(8'h50, 8'h77);
    check("R11 no walk outside window", csum_busy, 0);
    check("R11 no err in range", nv_err, 0);
    read_idx(7'd80, 8'h77, "R11 outside stored");

    repeat (3) step();
    summary();
  end
endmodule